// File: doc/BRIEF.md
# Local Bus Cycle Sequencer

This block sits behind a slave-side request port and turns each accepted read or write into a series of address and data phases on a local bus. How those phases are shaped is chosen by a per-space descriptor word. The descriptor selects the bus width, which sets the address step. It also sets a count of idle clocks between data phases, whether the local ready pin gates phase completion, whether bursts run freely or are capped, and whether bursts are allowed at all. A last group of fields decides how far a read prefetches.

A requester raises `req_valid` while `req_ready` is high. The sequencer captures the address, direction, length and descriptor in that cycle. It then drives `lb_ads` for one address phase, followed by one or more `lb_dphase` cycles. Every completed write phase pulses `wr_ack` so the requester can advance its write data. Every completed read phase presents `rd_data` with `rd_valid`. `done` marks the final phase, and `disc` flags a read that was cut to a single word because prefetch is off.

Top module: `lbus_cycle_seq`

## Requirements
- R1: The address of each data phase exceeds the previous phase's address by the width step: width code 00 steps by 1, code 01 by 2, codes 10 and 11 by 4 (width field is descriptor bits [5:4]).
- R2: Between two successive data phases of one request, exactly N clocks with neither `lb_ads` nor `lb_dphase` are inserted, where N (0 to 15) is descriptor bits [3:0].
- R3: With ready-enable (bit 8) set, a data phase completes only in a cycle where `lb_ready` is high, holding address and strobe until then; with it clear, every data-phase cycle completes and `lb_ready` has no effect.
- R4: With bursting on and burst-terminate-enable (bit 7) clear, at most 4 data phases follow one address phase; the next word then starts a new address phase.
- R5: With burst-terminate-enable set, `lb_bterm` high at a completing data phase makes the next word begin with a new address phase; otherwise the burst continues without limit.
- R6: With burst-enable (bit 6) clear, every word gets its own address phase; an address phase is always followed directly by a data phase.
- R7: With prefetch-disable (bit 10) set, a read transfers exactly one word and `done` and `disc` pulse together on that phase.
- R8: With prefetch enabled and count-enable (bit 9) set, a read transfers max(C,1) words, C being bits [14:11]; `done` pulses with the last.
- R9: With prefetch enabled and count-enable clear, a read continues until a completing phase sees `req_term` high, which ends the request after that word; `rd_data` carries `lb_rdata` of the completing phase.
- R10: A write transfers max(`req_len`,1) words, drives `lb_write` high, passes `req_wdata` onto `lb_wdata`, and pulses `wr_ack` for each completed phase.
- R11: The descriptor is captured when a request is accepted; changing `desc_word` during the request has no effect on it.
- R12: A synchronous reset, or the end of a request, returns the sequencer to idle with `req_ready` high and `lb_ads`, `lb_dphase` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Starting local address |
| req_len | input | LEN_W | Write length in longwords |
| req_wdata | input | DW | Current write word |
| req_term | input | 1 | Requester terminate for open-ended prefetch |
| desc_word | input | 15 | Space descriptor |
| lb_ready | input | 1 | Local ready |
| lb_bterm | input | 1 | Local burst terminate |
| lb_rdata | input | DW | Local read data |
| lb_ads | output | 1 | Address phase strobe |
| lb_dphase | output | 1 | Data phase strobe |
| lb_write | output | 1 | Direction of the current cycle |
| lb_addr | output | AW | Local address |
| lb_wdata | output | DW | Local write data |
| rd_valid | output | 1 | Read word completed |
| rd_data | output | DW | Read word |
| wr_ack | output | 1 | Write word completed |
| done | output | 1 | Last word of request completed |
| disc | output | 1 | Request ended by single-word read disconnect |

## Verification
Writes are run at all three widths, with bursting on and with it off, so that the address step and the count of address phases show whether the width decode and the single-cycle mode work. Some runs hold ready low while it is disabled, and others toggle it while it is enabled. Comparing the two separates real wait-on-ready from a pin that is wrongly sampled. Reads are tried with prefetch off, with counts of zero and seven, and open-ended with a requester terminate. These show whether the end of a read comes from the right source. One run toggles burst-terminate, one uses idle gaps and then changes the descriptor mid-request, and one resets in the middle of a burst; each targets the restart, gap and capture logic in turn.

// File: rtl/lbus_seq_pkg.sv
package lbus_seq_pkg;

    localparam int DESC_W = 15;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [3:0] gap;
        logic [2:0] step;
        logic       burst_en;
        logic       bterm_en;
        logic       rdy_en;
        logic       pf_cnt_en;
        logic       pf_dis;
        logic [3:0] pf_cnt;
    } desc_t;

endpackage

// File: rtl/lbus_desc_unpack.sv
module lbus_desc_unpack
    import lbus_seq_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    output desc_t             fields
);
    always_comb begin
        fields.gap       = raw[3:0];
        fields.burst_en  = raw[6];
        fields.bterm_en  = raw[7];
        fields.rdy_en    = raw[8];
        fields.pf_cnt_en = raw[9];
        fields.pf_dis    = raw[10];
        fields.pf_cnt    = raw[14:11];
        case (raw[5:4])
            2'b00:   fields.step = 3'd1;
            2'b01:   fields.step = 3'd2;
            default: fields.step = 3'd4;
        endcase
    end
endmodule

// File: rtl/lbus_burst_policy.sv
module lbus_burst_policy
    import lbus_seq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CAP   = 4,
    localparam int BEAT_W = (CAP > 1) ? $clog2(CAP) : 1
) (
    input  desc_t             desc,
    input  logic              is_write,
    input  logic [LEN_W-1:0]  words_left,
    input  logic [BEAT_W-1:0] beats,
    input  logic              bterm_pin,
    input  logic              term_req,
    output logic              last_word,
    output logic              restart
);
    always_comb begin
        if (is_write)            last_word = (words_left == LEN_W'(1));
        else if (desc.pf_dis)    last_word = 1'b1;
        else if (desc.pf_cnt_en) last_word = (words_left == LEN_W'(1));
        else                     last_word = term_req;

        if (!desc.burst_en)      restart = 1'b1;
        else if (desc.bterm_en)  restart = bterm_pin;
        else                     restart = (beats == BEAT_W'(CAP - 1));
    end
endmodule

// File: rtl/lbus_gap_ctr.sv
module lbus_gap_ctr (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [3:0] load_val,
    output logic       expire
);
    logic [3:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = load_val;
        else if (cnt_q != 4'd0) cnt_d = cnt_q - 4'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= 4'd0;
        else     cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == 4'd1);

    // R2: a loaded gap never exceeds the field range and counts down steadily
    assert_gap_countdown_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != 4'd0) |=> (cnt_q == $past(cnt_q) - 4'd1));
endmodule

// File: rtl/lbus_cycle_seq.sv
module lbus_cycle_seq
    import lbus_seq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LEN_W = 8,
    parameter int CAP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DW-1:0]     req_wdata,
    input  logic              req_term,
    input  logic [DESC_W-1:0] desc_word,
    input  logic              lb_ready,
    input  logic              lb_bterm,
    input  logic [DW-1:0]     lb_rdata,
    output logic              lb_ads,
    output logic              lb_dphase,
    output logic              lb_write,
    output logic [AW-1:0]     lb_addr,
    output logic [DW-1:0]     lb_wdata,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              wr_ack,
    output logic              done,
    output logic              disc
);
    localparam int BEAT_W = (CAP > 1) ? $clog2(CAP) : 1;
    localparam int MON_W  = $clog2(CAP + 1) + 1;

    typedef struct packed {
        seq_state_e        state;
        logic [AW-1:0]     addr;
        logic [LEN_W-1:0]  left;
        logic [BEAT_W-1:0] beats;
        desc_t             desc;
        logic              write;
        logic              pend_restart;
    } seq_t;

    seq_t  st_d, st_q;
    desc_t desc_in;
    logic  complete, last_word, restart, gap_load, gap_expire;

    lbus_desc_unpack i_unpack (
        .raw    (desc_word),
        .fields (desc_in)
    );

    lbus_burst_policy #(.LEN_W(LEN_W), .CAP(CAP)) i_policy (
        .desc       (st_q.desc),
        .is_write   (st_q.write),
        .words_left (st_q.left),
        .beats      (st_q.beats),
        .bterm_pin  (lb_bterm),
        .term_req   (req_term),
        .last_word  (last_word),
        .restart    (restart)
    );

    lbus_gap_ctr i_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (st_q.desc.gap),
        .expire   (gap_expire)
    );

    assign complete = (st_q.state == ST_DATA) && (!st_q.desc.rdy_en || lb_ready);

    always_comb begin
        st_d     = st_q;
        gap_load = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.state = ST_ADDR;
                    st_d.addr  = req_addr;
                    st_d.write = req_write;
                    st_d.desc  = desc_in;
                    st_d.beats = '0;
                    if (req_write)
                        st_d.left = (req_len == '0) ? LEN_W'(1) : req_len;
                    else if (desc_in.pf_cnt == 4'd0)
                        st_d.left = LEN_W'(1);
                    else
                        st_d.left = LEN_W'(desc_in.pf_cnt);
                end
            end
            ST_ADDR: st_d.state = ST_DATA;
            ST_DATA: begin
                if (complete) begin
                    if (last_word) begin
                        st_d.state = ST_IDLE;
                    end else begin
                        st_d.addr  = st_q.addr + AW'(st_q.desc.step);
                        st_d.left  = st_q.left - LEN_W'(1);
                        st_d.beats = restart ? '0 : st_q.beats + BEAT_W'(1);
                        if (st_q.desc.gap != 4'd0) begin
                            gap_load          = 1'b1;
                            st_d.pend_restart = restart;
                            st_d.state        = ST_GAP;
                        end else begin
                            st_d.state = restart ? ST_ADDR : ST_DATA;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (gap_expire) st_d.state = st_q.pend_restart ? ST_ADDR : ST_DATA;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.state        <= ST_IDLE;
            st_q.addr         <= '0;
            st_q.left         <= '0;
            st_q.beats        <= '0;
            st_q.desc         <= '0;
            st_q.write        <= 1'b0;
            st_q.pend_restart <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.state == ST_IDLE);
    assign lb_ads    = (st_q.state == ST_ADDR);
    assign lb_dphase = (st_q.state == ST_DATA);
    assign lb_write  = st_q.write;
    assign lb_addr   = st_q.addr;
    assign lb_wdata  = req_wdata;
    assign rd_data   = lb_rdata;
    assign rd_valid  = complete && !st_q.write;
    assign wr_ack    = complete && st_q.write;
    assign done      = complete && last_word;
    assign disc      = done && !st_q.write && st_q.desc.pf_dis;

    // Port-level beat counter used only by the burst-cap check
    logic [MON_W-1:0] mon_beats_d, mon_beats_q;
    always_comb begin
        mon_beats_d = mon_beats_q;
        if (lb_ads)                 mon_beats_d = '0;
        else if (rd_valid || wr_ack) mon_beats_d = mon_beats_q + MON_W'(1);
    end
    always_ff @(posedge clk) begin
        if (rst) mon_beats_q <= '0;
        else     mon_beats_q <= mon_beats_d;
    end

    assert_ads_then_data_R6: assert property (@(posedge clk) disable iff (rst)
        lb_ads |=> lb_dphase);

    assert_single_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        ((rd_valid || wr_ack) && !done && !st_q.desc.burst_en) |=> !lb_dphase);

    assert_ready_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (lb_dphase && st_q.desc.rdy_en && !lb_ready) |=> (lb_dphase && $stable(lb_addr)));

    assert_burst_cap_R4: assert property (@(posedge clk) disable iff (rst)
        (lb_dphase && st_q.desc.burst_en && !st_q.desc.bterm_en) |-> (mon_beats_q < MON_W'(CAP)));

    assert_prefetch_off_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && st_q.desc.pf_dis) |-> (done && disc));

    assert_desc_held_R11: assert property (@(posedge clk) disable iff (rst)
        (lb_ads || lb_dphase) |=> (req_ready || $stable(st_q.desc)));

    assert_idle_after_done_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> (req_ready && !lb_ads && !lb_dphase));

    assert_reset_idle_R12: assert property (@(posedge clk)
        rst |=> (req_ready && !lb_ads && !lb_dphase));
endmodule

// File: tb/test_lbus_cycle_seq.sv
module test_lbus_cycle_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_term = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0, lb_rdata = '0;
    logic [7:0]  req_len = '0;
    logic [14:0] desc_word = '0;
    logic        lb_ready = 1'b0, lb_bterm = 1'b0;
    logic        req_ready, lb_ads, lb_dphase, lb_write, rd_valid, wr_ack, done, disc;
    logic [31:0] lb_addr, lb_wdata, rd_data;

    always #4 clk = ~clk;

    lbus_cycle_seq i_lbus_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .req_term(req_term), .desc_word(desc_word),
        .lb_ready(lb_ready), .lb_bterm(lb_bterm), .lb_rdata(lb_rdata),
        .lb_ads(lb_ads), .lb_dphase(lb_dphase), .lb_write(lb_write),
        .lb_addr(lb_addr), .lb_wdata(lb_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .wr_ack(wr_ack), .done(done), .disc(disc)
    );

    int checks = 0, failures = 0, cyc = 0;
    int words_seen = 0, ads_seen = 0;
    bit done_seen = 0, disc_seen = 0, started = 0;

    // behavioural reference state
    int ms = 0, mleft = 0, mbeats = 0, mwait = 0;
    logic [31:0] maddr = '0;
    int mstep = 4, mws = 0;
    bit mwr, mrdy, mbt, mbe, mpfd, mpce, mpend;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [14:0] mk(input int ws, input int wid, input bit be, input bit bt,
                                       input bit rdy, input bit pce, input bit pfd, input int cnt);
        logic [14:0] v;
        v = '0;
        v[3:0] = 4'(ws); v[5:4] = 2'(wid); v[6] = be; v[7] = bt;
        v[8] = rdy; v[9] = pce; v[10] = pfd; v[14:11] = 4'(cnt);
        return v;
    endfunction

    // sample 1 ns before each rising edge, then advance the reference
    always begin
        bit cmp, lst, rs;
        @(negedge clk); #3;
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        cmp = (ms == 2) && (!mrdy || lb_ready);
        lst = mwr ? (mleft == 1) : mpfd ? 1'b1 : mpce ? (mleft == 1) : req_term;
        if (started) begin
            chk(req_ready == (ms == 0), "R12 req_ready", req_ready, ms == 0);
            chk(lb_ads == (ms == 1), "R6 lb_ads", lb_ads, ms == 1);
            chk(lb_dphase == (ms == 2), "R2 lb_dphase", lb_dphase, ms == 2);
            if (ms == 1 || ms == 2) begin
                chk(lb_addr == maddr, "R1 lb_addr", lb_addr, maddr);
                chk(lb_write == mwr, "R10 lb_write", lb_write, mwr);
            end
            chk(rd_valid == (cmp && !mwr), "R3 rd_valid", rd_valid, cmp && !mwr);
            chk(wr_ack == (cmp && mwr), "R3 wr_ack", wr_ack, cmp && mwr);
            chk(done == (cmp && lst), "R8 done", done, cmp && lst);
            chk(disc == (cmp && lst && !mwr && mpfd), "R7 disc", disc, cmp && lst && !mwr && mpfd);
            if (rd_valid) chk(rd_data == lb_rdata, "R9 rd_data", rd_data, lb_rdata);
            if (ms == 2 && mwr) chk(lb_wdata == req_wdata, "R10 lb_wdata", lb_wdata, req_wdata);
            if (lb_ads) ads_seen++;
            if (rd_valid || wr_ack) words_seen++;
            if (done) done_seen = 1;
            if (disc) disc_seen = 1;
        end
        if (rst) begin
            ms = 0; started = 1;
        end else begin
            case (ms)
                0: if (req_valid) begin
                    mws = int'(desc_word[3:0]);
                    mstep = (desc_word[5:4] == 2'b00) ? 1 : (desc_word[5:4] == 2'b01) ? 2 : 4;
                    mbe = desc_word[6]; mbt = desc_word[7]; mrdy = desc_word[8];
                    mpce = desc_word[9]; mpfd = desc_word[10];
                    mwr = req_write; maddr = req_addr; mbeats = 0;
                    if (req_write) mleft = (req_len == 0) ? 1 : int'(req_len);
                    else mleft = (desc_word[14:11] == 0) ? 1 : int'(desc_word[14:11]);
                    ms = 1;
                end
                1: ms = 2;
                2: if (cmp) begin
                    if (lst) ms = 0;
                    else begin
                        maddr = maddr + 32'(mstep);
                        mleft--;
                        rs = !mbe || (mbt ? lb_bterm : (mbeats == 3));
                        mbeats = rs ? 0 : mbeats + 1;
                        if (mws > 0) begin mwait = mws; mpend = rs; ms = 3; end
                        else ms = rs ? 1 : 2;
                    end
                end
                default: if (mwait == 1) ms = mpend ? 1 : 2; else mwait--;
            endcase
        end
    end

    task automatic drive_pins(input int rdy_mode, input bit bt_mode, input int term_n);
        lb_ready  = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 != 0) : 1'b0;
        lb_bterm  = bt_mode && (cyc % 2 == 0);
        req_term  = (term_n > 0) && (words_seen == term_n - 1);
        lb_rdata  = 32'(cyc * 3 + 1);
        req_wdata = 32'(cyc) ^ 32'h5a5a_0000;
    endtask

    task automatic run_req(input bit wr, input logic [31:0] a, input int len, input logic [14:0] dw,
                           input int rdy_mode, input bit bt_mode, input int term_n,
                           input int exp_words, input int exp_ads, input bit exp_disc,
                           input bit flip, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        words_seen = 0; ads_seen = 0; done_seen = 0; disc_seen = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_len = 8'(len); desc_word = dw;
        drive_pins(rdy_mode, bt_mode, term_n);
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) desc_word = ~dw;
        while (!done_seen) begin
            drive_pins(rdy_mode, bt_mode, term_n);
            @(negedge clk);
        end
        chk(words_seen == exp_words, {tag, " words"}, words_seen, exp_words);
        if (exp_ads >= 0) chk(ads_seen == exp_ads, {tag, " address phases"}, ads_seen, exp_ads);
        chk(disc_seen == exp_disc, {tag, " disconnect"}, disc_seen, exp_disc);
        desc_word = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #3;
        chk(req_ready && !lb_ads && !lb_dphase, "R12 reset idle", {req_ready, lb_ads, lb_dphase}, 3'b100);
        // R4 cap of 4, R3 ready ignored while disabled (ready held low)
        run_req(1, 32'h100, 6, mk(0, 2, 1, 0, 0, 0, 0, 0), 2, 0, 0, 6, 2, 0, 0, "R4 R3 capped write");
        // R6 single cycles, R1 byte stepping
        run_req(1, 32'h203, 5, mk(0, 0, 0, 0, 0, 0, 0, 0), 0, 0, 0, 5, 5, 0, 0, "R6 R1 single-cycle write");
        // R5 burst terminate with R2 gaps, R1 halfword stepping
        run_req(1, 32'h300, 4, mk(3, 1, 1, 1, 0, 0, 0, 0), 0, 1, 0, 4, -1, 0, 0, "R5 R2 bterm write");
        // R7 prefetch off
        run_req(0, 32'h400, 9, mk(0, 3, 1, 0, 0, 1, 1, 9), 0, 0, 0, 1, 1, 1, 0, "R7 prefetch off read");
        // R8 counted prefetch of 7, R3 ready toggling
        run_req(0, 32'h500, 1, mk(0, 2, 1, 0, 1, 1, 0, 7), 1, 0, 0, 7, 2, 0, 0, "R8 R3 counted read");
        // R8 count of zero gives one word
        run_req(0, 32'h600, 1, mk(0, 2, 1, 0, 0, 1, 0, 0), 0, 0, 0, 1, 1, 0, 0, "R8 zero count read");
        // R9 open prefetch until terminate, R5 no bterm means unlimited burst
        run_req(0, 32'h700, 1, mk(0, 2, 1, 1, 0, 0, 0, 0), 0, 0, 9, 9, 1, 0, 0, "R9 R5 open read");
        // R9 open prefetch with R4 cap and R2 gap
        run_req(0, 32'h800, 1, mk(2, 2, 1, 0, 0, 0, 0, 0), 0, 0, 5, 5, 2, 0, 0, "R9 R2 open capped read");
        // R10 zero length write is one word
        run_req(1, 32'h900, 0, mk(0, 2, 1, 0, 0, 0, 0, 0), 0, 0, 0, 1, 1, 0, 0, "R10 zero length write");
        // R11 descriptor flipped after acceptance
        run_req(1, 32'hA00, 6, mk(1, 2, 1, 0, 0, 0, 0, 0), 0, 0, 0, 6, 2, 0, 1, "R11 descriptor held");
        // R12 reset in the middle of a burst
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'hB00; req_len = 8'd8;
        desc_word = mk(0, 2, 1, 1, 0, 0, 0, 0); lb_ready = 1'b1; lb_bterm = 1'b0;
        @(negedge clk); req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0; #3;
        chk(req_ready && !lb_ads && !lb_dphase, "R12 mid-burst reset", {req_ready, lb_ads, lb_dphase}, 3'b100);
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule